// File: doc/BRIEF.md
# Cache Error Trap Dispatcher

This block holds the error-enable register of a processor's external cache and turns error events that arrive already detected and classified into trap requests and sticky status bits. Each event carries an error kind, the operation that was running when the error appeared, and for interrupt-vector fetches a route selector. Three enable bits choose which error families may raise a trap. The operation decides which of four trap types is raised. Every event is logged in a status bit whether or not its trap is enabled.

The same register holds two force controls. While a force control is set, the block drives a stored check value into the tag or data ECC generator as an override.

Top module: `cache_err_dispatch`

## Requirements
- R1: After reset, the register reads zero, all four trap outputs are low, all status bits are clear, and both override enables and override values are zero.
- R2: A write sets the register. Bit 0 enables traps for corrected errors, bit 1 for uncorrectable and system errors, and bit 3 for the fast trap. Bits 12:4 hold the forced data check value, bit 13 forces data, bits 17:14 hold the forced tag check value, and bit 18 forces the tag. Bit 2 is reserved: it reads zero and writes to it are ignored.
- R3: The data override enable follows bit 13, and the data override value equals bits 12:4 while bit 13 is set and is zero otherwise. The tag override follows the same rule with bit 18 and bits 17:14.
- R4: Kinds are coded as follows: 0 cache software-correctable, 1 cache uncorrectable, 2 bus data uncorrectable, 3 bus tag uncorrectable, 4 bus timeout, 5 bus error, 6 hardware-corrected data, 7 hardware-corrected tag. Origins are coded as follows: 0 fetch, 1 load, 2 atomic, 3 store merge, 4 writeback, 5 copyout, 6 vector fetch; code 7 acts as writeback. A cache error of kind 0 or 1 on origin 0, 1 or 2 pulses the fast trap when bit 3 is set, and raises no other trap.
- R5: A kind-1 cache error on origin 3, 4 or 5 never pulses the fast trap. With bit 1 set it pulses the disrupting trap. A kind-0 error on these origins is treated as corrected.
- R6: With bit 1 set, an uncorrectable or system error (kind 1 off the local-read origins, or kind 2 to 5) is routed by origin: origin 0 pulses the instruction-access trap, origins 1 and 2 pulse the data-access trap, and origins 3, 4, 5 and 7 pulse the disrupting trap.
- R7: An uncorrectable or system error on origin 6 is routed by the 2-bit selector: 0 pulses the instruction-access trap, 1 pulses the data-access trap, and 2 or 3 pulse the disrupting trap. This needs bit 1.
- R8: With bit 0 set, a corrected error (kind 6, kind 7, or kind 0 off the local-read origins) pulses the disrupting trap on any origin.
- R9: Each event sets exactly one status bit, whatever the enables. The bit indices are: 0 fast software-correctable, 1 fast uncorrectable, 2 bus tag uncorrectable, 3 merge uncorrectable, 4 writeback uncorrectable (origin 4 or 7), 5 copyout uncorrectable, 6 vector uncorrectable (kind 1 or 2 on origin 6), 7 bus data uncorrectable, 8 bus error, 9 timeout, 10 corrected data, 11 corrected tag.
- R10: Status bits are sticky. A 1 on a clear-vector bit clears that bit one cycle later. An event that sets the same bit in the same cycle wins, so the bit stays set.
- R11: Trap outputs and status change one cycle after the event. Each event gives exactly one cycle of its trap, so events on back-to-back cycles give a trap high on both cycles. At most one trap is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 19 | Register write data |
| cfg_rdata_o | output | 19 | Register read data |
| evt_valid_i | input | 1 | Error event present this cycle |
| evt_kind_i | input | 3 | Error kind code |
| evt_origin_i | input | 3 | Originating operation code |
| evt_vsel_i | input | 2 | Trap route for vector-fetch errors |
| stat_clr_i | input | 12 | Write-one-to-clear mask for status |
| stat_o | output | 12 | Sticky status bits |
| trap_fast_o | output | 1 | Fast ECC trap pulse |
| trap_iacc_o | output | 1 | Instruction-access error trap pulse |
| trap_dacc_o | output | 1 | Data-access error trap pulse |
| trap_disr_o | output | 1 | Disrupting ECC error trap pulse |
| ovr_data_en_o | output | 1 | Data check-bit override enable |
| ovr_data_chk_o | output | 9 | Data check-bit override value |
| ovr_tag_en_o | output | 1 | Tag check-bit override enable |
| ovr_tag_chk_o | output | 4 | Tag check-bit override value |

## Verification
A wrong routing decode shows on the very next cycle, as the wrong trap pulse or a missing pulse, together with a status bit at the wrong index. A status bit that is corrupted or cleared when it should not be stays visible on `stat_o` from that cycle until a matching clear, so the bench compares the status vector after every cycle. A register bit that is stored wrongly shows at once on the read port and the override outputs. It also shows on the first event whose trap that bit gates.

// File: rtl/cerr_pkg.sv
package cerr_pkg;

   typedef enum logic [2:0] {
      K_CACHE_SWC = 3'd0,
      K_CACHE_UNC = 3'd1,
      K_BUS_DUNC  = 3'd2,
      K_BUS_TUNC  = 3'd3,
      K_BUS_TMO   = 3'd4,
      K_BUS_BERR  = 3'd5,
      K_HWC_DATA  = 3'd6,
      K_HWC_TAG   = 3'd7
   } err_kind_t;

   typedef enum logic [2:0] {
      O_FETCH   = 3'd0,
      O_LOAD    = 3'd1,
      O_ATOMIC  = 3'd2,
      O_MERGE   = 3'd3,
      O_WBACK   = 3'd4,
      O_COPYOUT = 3'd5,
      O_VECTOR  = 3'd6,
      O_SPARE   = 3'd7
   } err_origin_t;

   typedef enum logic [1:0] {
      V_FETCH = 2'd0,
      V_LOAD  = 2'd1,
      V_DISR  = 2'd2,
      V_DISR2 = 2'd3
   } vec_route_t;

   typedef struct packed {
      logic fast;
      logic iacc;
      logic dacc;
      logic disr;
   } trap_vec_t;

   localparam int NSTAT       = 12;
   localparam int S_FAST_SWC  = 0;
   localparam int S_FAST_UNC  = 1;
   localparam int S_TAG_UNC   = 2;
   localparam int S_MERGE_UNC = 3;
   localparam int S_WB_UNC    = 4;
   localparam int S_CPY_UNC   = 5;
   localparam int S_VEC_UNC   = 6;
   localparam int S_BUS_UNC   = 7;
   localparam int S_BUS_ERR   = 8;
   localparam int S_TIMEOUT   = 9;
   localparam int S_CORR_DATA = 10;
   localparam int S_CORR_TAG  = 11;

endpackage

// File: rtl/cerr_cfg_reg.sv
module cerr_cfg_reg #(
   parameter int DW        = 9,
   parameter int TW        = 4,
   parameter bit GATE_VAL  = 1'b1,
   localparam int REG_W    = DW + TW + 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] rdata_o,
   output logic             en_corr_o,
   output logic             en_unc_o,
   output logic             en_fast_o,
   output logic             frc_data_o,
   output logic [DW-1:0]    frc_data_val_o,
   output logic             frc_tag_o,
   output logic [TW-1:0]    frc_tag_val_o
);
   localparam int P_CORR = 0;
   localparam int P_UNC  = 1;
   localparam int P_FAST = 3;
   localparam int P_DLO  = 4;
   localparam int P_FD   = P_DLO + DW;
   localparam int P_TLO  = P_FD + 1;
   localparam int P_FT   = P_TLO + TW;

   initial begin
      assert_width_ok_R2 : assert (DW >= 1 && DW <= 32 && TW >= 1 && TW <= 32)
         else $error("check-value widths out of range");
      assert_layout_ok_R2 : assert (P_FT == REG_W - 1)
         else $error("register layout does not fill REG_W");
   end

   logic          en_corr_q, en_unc_q, en_fast_q, frc_d_q, frc_t_q;
   logic [DW-1:0] dval_q;
   logic [TW-1:0] tval_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_corr_q <= 1'b0;
         en_unc_q  <= 1'b0;
         en_fast_q <= 1'b0;
         frc_d_q   <= 1'b0;
         frc_t_q   <= 1'b0;
         dval_q    <= '0;
         tval_q    <= '0;
      end else if (wr_i) begin
         en_corr_q <= wdata_i[P_CORR];
         en_unc_q  <= wdata_i[P_UNC];
         en_fast_q <= wdata_i[P_FAST];
         frc_d_q   <= wdata_i[P_FD];
         frc_t_q   <= wdata_i[P_FT];
         dval_q    <= wdata_i[P_DLO +: DW];
         tval_q    <= wdata_i[P_TLO +: TW];
      end
   end

   always_comb begin
      rdata_o               = '0;
      rdata_o[P_CORR]       = en_corr_q;
      rdata_o[P_UNC]        = en_unc_q;
      rdata_o[P_FAST]       = en_fast_q;
      rdata_o[P_DLO +: DW]  = dval_q;
      rdata_o[P_FD]         = frc_d_q;
      rdata_o[P_TLO +: TW]  = tval_q;
      rdata_o[P_FT]         = frc_t_q;
   end

   assign en_corr_o  = en_corr_q;
   assign en_unc_o   = en_unc_q;
   assign en_fast_o  = en_fast_q;
   assign frc_data_o = frc_d_q;
   assign frc_tag_o  = frc_t_q;

   generate
      if (GATE_VAL) begin : g_gated
         assign frc_data_val_o = frc_d_q ? dval_q : '0;
         assign frc_tag_val_o  = frc_t_q ? tval_q : '0;

         assert_data_idle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            !frc_data_o |-> frc_data_val_o == '0);
         assert_tag_idle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            !frc_tag_o |-> frc_tag_val_o == '0);
      end else begin : g_raw
         assign frc_data_val_o = dval_q;
         assign frc_tag_val_o  = tval_q;
      end
   endgenerate

endmodule

// File: rtl/cerr_route.sv
module cerr_route
   import cerr_pkg::*;
(
   input  logic                 valid_i,
   input  err_kind_t            kind_i,
   input  err_origin_t          origin_i,
   input  vec_route_t           vsel_i,
   input  logic                 en_corr_i,
   input  logic                 en_unc_i,
   input  logic                 en_fast_i,
   output trap_vec_t            trap_o,
   output logic [NSTAT-1:0]     set_o
);
   logic local_rd, cache_kind, fast_cls, corr_cls, unc_cls;
   int   sidx;

   always_comb begin
      local_rd   = (origin_i == O_FETCH) || (origin_i == O_LOAD) || (origin_i == O_ATOMIC);
      cache_kind = (kind_i == K_CACHE_SWC) || (kind_i == K_CACHE_UNC);
      fast_cls   = cache_kind && local_rd;
      corr_cls   = !fast_cls && ((kind_i == K_CACHE_SWC) || (kind_i == K_HWC_DATA) ||
                                 (kind_i == K_HWC_TAG));
      unc_cls    = !fast_cls && !corr_cls;

      // status index selection
      case (kind_i)
         K_CACHE_SWC: sidx = local_rd ? S_FAST_SWC : S_CORR_DATA;
         K_CACHE_UNC: begin
            case (origin_i)
               O_MERGE:   sidx = S_MERGE_UNC;
               O_COPYOUT: sidx = S_CPY_UNC;
               O_VECTOR:  sidx = S_VEC_UNC;
               O_WBACK, O_SPARE: sidx = S_WB_UNC;
               default:   sidx = S_FAST_UNC;
            endcase
         end
         K_BUS_DUNC: sidx = (origin_i == O_VECTOR) ? S_VEC_UNC : S_BUS_UNC;
         K_BUS_TUNC: sidx = S_TAG_UNC;
         K_BUS_TMO:  sidx = S_TIMEOUT;
         K_BUS_BERR: sidx = S_BUS_ERR;
         K_HWC_DATA: sidx = S_CORR_DATA;
         default:    sidx = S_CORR_TAG;
      endcase

      set_o = '0;
      if (valid_i) set_o[sidx] = 1'b1;

      // trap selection
      trap_o = '0;
      if (valid_i) begin
         if (fast_cls) begin
            trap_o.fast = en_fast_i;
         end else if (corr_cls) begin
            trap_o.disr = en_corr_i;
         end else if (unc_cls && en_unc_i) begin
            case (origin_i)
               O_FETCH:          trap_o.iacc = 1'b1;
               O_LOAD, O_ATOMIC: trap_o.dacc = 1'b1;
               O_VECTOR: begin
                  case (vsel_i)
                     V_FETCH: trap_o.iacc = 1'b1;
                     V_LOAD:  trap_o.dacc = 1'b1;
                     default: trap_o.disr = 1'b1;
                  endcase
               end
               default:          trap_o.disr = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/cerr_status.sv
module cerr_status #(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] st_o
);
   initial begin
      assert_count_ok_R9 : assert (N >= 1 && N <= 64)
         else $error("status count out of range");
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)           bit_q <= 1'b0;
            else if (set_i[i])    bit_q <= 1'b1;
            else if (clr_i[i])    bit_q <= 1'b0;
         end
         assign st_o[i] = bit_q;

         assert_sticky_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            (st_o[i] && !clr_i[i]) |=> st_o[i]);
         assert_set_wins_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> st_o[i]);
         assert_clear_acts_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !st_o[i]);
      end
   endgenerate

endmodule

// File: rtl/cache_err_dispatch.sv
module cache_err_dispatch
   import cerr_pkg::*;
#(
   parameter int DW       = 9,
   parameter int TW       = 4,
   parameter bit GATE_VAL = 1'b1,
   localparam int REG_W   = DW + TW + 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_i,
   input  logic [REG_W-1:0] cfg_wdata_i,
   output logic [REG_W-1:0] cfg_rdata_o,
   input  logic             evt_valid_i,
   input  logic [2:0]       evt_kind_i,
   input  logic [2:0]       evt_origin_i,
   input  logic [1:0]       evt_vsel_i,
   input  logic [NSTAT-1:0] stat_clr_i,
   output logic [NSTAT-1:0] stat_o,
   output logic             trap_fast_o,
   output logic             trap_iacc_o,
   output logic             trap_dacc_o,
   output logic             trap_disr_o,
   output logic             ovr_data_en_o,
   output logic [DW-1:0]    ovr_data_chk_o,
   output logic             ovr_tag_en_o,
   output logic [TW-1:0]    ovr_tag_chk_o
);
   logic             en_corr, en_unc, en_fast;
   trap_vec_t        trap_d, trap_q;
   logic [NSTAT-1:0] set_vec;

   cerr_cfg_reg #(.DW(DW), .TW(TW), .GATE_VAL(GATE_VAL)) u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_i           (cfg_wr_i),
      .wdata_i        (cfg_wdata_i),
      .rdata_o        (cfg_rdata_o),
      .en_corr_o      (en_corr),
      .en_unc_o       (en_unc),
      .en_fast_o      (en_fast),
      .frc_data_o     (ovr_data_en_o),
      .frc_data_val_o (ovr_data_chk_o),
      .frc_tag_o      (ovr_tag_en_o),
      .frc_tag_val_o  (ovr_tag_chk_o)
   );

   cerr_route u_route (
      .valid_i   (evt_valid_i),
      .kind_i    (err_kind_t'(evt_kind_i)),
      .origin_i  (err_origin_t'(evt_origin_i)),
      .vsel_i    (vec_route_t'(evt_vsel_i)),
      .en_corr_i (en_corr),
      .en_unc_i  (en_unc),
      .en_fast_i (en_fast),
      .trap_o    (trap_d),
      .set_o     (set_vec)
   );

   cerr_status #(.N(NSTAT)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (stat_clr_i),
      .st_o  (stat_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) trap_q <= '0;
      else        trap_q <= trap_d;
   end

   assign trap_fast_o = trap_q.fast;
   assign trap_iacc_o = trap_q.iacc;
   assign trap_dacc_o = trap_q.dacc;
   assign trap_disr_o = trap_q.disr;

   assert_one_trap_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_fast_o, trap_iacc_o, trap_dacc_o, trap_disr_o}));
   assert_one_status_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_i |-> $countones(set_vec) == 1);
   assert_trap_logged_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fast_o || trap_iacc_o || trap_dacc_o || trap_disr_o) |-> (stat_o != '0));
   assert_no_event_no_trap_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid_i |=> !(trap_fast_o || trap_iacc_o || trap_dacc_o || trap_disr_o));
   assert_fast_gated_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_fast |=> !trap_fast_o);
   assert_unc_gated_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_unc |=> !(trap_iacc_o || trap_dacc_o));

endmodule

// File: tb/cache_err_dispatch_test.sv
module cache_err_dispatch_test;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 19;
   localparam int NS = 12;
   localparam logic [RW-1:0] WMASK = 19'h7FFFB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [RW-1:0] cfg_wdata = '0;
   logic [RW-1:0] cfg_rdata;
   logic          evt_valid = 1'b0;
   logic [2:0]    evt_kind = '0, evt_origin = '0;
   logic [1:0]    evt_vsel = '0;
   logic [NS-1:0] stat_clr = '0, stat;
   logic          t_fast, t_iacc, t_dacc, t_disr;
   logic          od_en, ot_en;
   logic [8:0]    od_chk;
   logic [3:0]    ot_chk;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [RW-1:0] m_cfg = '0;
   logic [NS-1:0] m_stat = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cache_err_dispatch uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .evt_valid_i(evt_valid), .evt_kind_i(evt_kind),
      .evt_origin_i(evt_origin), .evt_vsel_i(evt_vsel), .stat_clr_i(stat_clr),
      .stat_o(stat), .trap_fast_o(t_fast), .trap_iacc_o(t_iacc),
      .trap_dacc_o(t_dacc), .trap_disr_o(t_disr), .ovr_data_en_o(od_en),
      .ovr_data_chk_o(od_chk), .ovr_tag_en_o(ot_en), .ovr_tag_chk_o(ot_chk)
   );

   // expected status index per R4/R5/R9
   function automatic int exp_idx(logic [2:0] k, logic [2:0] o);
      bit lr = (o <= 3'd2);
      case (k)
         3'd0: return lr ? 0 : 10;
         3'd1: begin
            if (lr) return 1;
            case (o)
               3'd3: return 3;
               3'd5: return 5;
               3'd6: return 6;
               default: return 4;
            endcase
         end
         3'd2: return (o == 3'd6) ? 6 : 7;
         3'd3: return 2;
         3'd4: return 9;
         3'd5: return 8;
         3'd6: return 10;
         default: return 11;
      endcase
   endfunction

   // expected traps {fast,iacc,dacc,disr} per R4-R8
   function automatic logic [3:0] exp_trap(logic [2:0] k, logic [2:0] o, logic [1:0] vs,
                                           logic [RW-1:0] c);
      bit lr = (o <= 3'd2);
      if ((k == 3'd0 || k == 3'd1) && lr) return {c[3], 3'b000};
      if (k == 3'd0 || k == 3'd6 || k == 3'd7) return {3'b000, c[0]};
      if (!c[1]) return 4'b0000;
      case (o)
         3'd0: return 4'b0100;
         3'd1, 3'd2: return 4'b0010;
         3'd6: return (vs == 2'd0) ? 4'b0100 : (vs == 2'd1) ? 4'b0010 : 4'b0001;
         default: return 4'b0001;
      endcase
   endfunction

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_outputs(string tag, logic [3:0] et);
      logic [3:0] at = {t_fast, t_iacc, t_dacc, t_disr};
      check(at == et, tag, "traps", 32'(at), 32'(et));
      check(stat == m_stat, tag, "status", 32'(stat), 32'(m_stat));
      check(cfg_rdata == m_cfg, tag, "rdata", 32'(cfg_rdata), 32'(m_cfg));
      check({od_en, od_chk} == {m_cfg[13], m_cfg[13] ? m_cfg[12:4] : 9'd0}, tag, "data ovr",
            32'({od_en, od_chk}), 32'({m_cfg[13], m_cfg[13] ? m_cfg[12:4] : 9'd0}));
      check({ot_en, ot_chk} == {m_cfg[18], m_cfg[18] ? m_cfg[17:14] : 4'd0}, tag, "tag ovr",
            32'({ot_en, ot_chk}), 32'({m_cfg[18], m_cfg[18] ? m_cfg[17:14] : 4'd0}));
   endtask

   // called at a negedge; returns at the following negedge after checking
   task automatic step(bit wr, logic [RW-1:0] wd, bit ev, logic [2:0] k, logic [2:0] o,
                       logic [1:0] vs, logic [NS-1:0] clr, string tag);
      logic [3:0]    et = '0;
      logic [NS-1:0] setv = '0;
      cfg_wr = wr; cfg_wdata = wd; evt_valid = ev; evt_kind = k; evt_origin = o;
      evt_vsel = vs; stat_clr = clr;
      if (ev) begin
         et = exp_trap(k, o, vs, m_cfg);
         setv[exp_idx(k, o)] = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      m_stat = (m_stat & ~clr) | setv;
      if (wr) m_cfg = wd & WMASK;
      cfg_wr = 1'b0; evt_valid = 1'b0; stat_clr = '0;
      check_outputs(tag, et);
   endtask

   task automatic cfg(logic [RW-1:0] v, string tag);
      step(1'b1, v, 1'b0, 3'd0, 3'd0, 2'd0, '0, tag);
   endtask

   task automatic evt(logic [2:0] k, logic [2:0] o, logic [1:0] vs, string tag);
      step(1'b0, '0, 1'b1, k, o, vs, '0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outputs("R1", 4'b0000);

      // R2 R3: layout, reserved bit, overrides
      cfg(19'h7FFFF, "R2");
      check(cfg_rdata == 19'h7FFFB, "R2", "reserved bit", 32'(cfg_rdata), 32'h7FFFB);
      cfg(19'h2A5A0, "R3");
      cfg(19'h1E1F0, "R3");
      cfg(19'h00000, "R3");

      // R4 fast trap
      cfg(19'h00008, "R4");
      evt(3'd1, 3'd1, 2'd0, "R4");
      evt(3'd0, 3'd0, 2'd0, "R4");
      evt(3'd1, 3'd2, 2'd0, "R4");
      // R5 no fast trap off local reads
      evt(3'd1, 3'd4, 2'd0, "R5");
      evt(3'd1, 3'd3, 2'd0, "R5");
      cfg(19'h0000A, "R5");
      evt(3'd1, 3'd5, 2'd0, "R5");
      evt(3'd1, 3'd7, 2'd0, "R5");
      // R6 routing
      cfg(19'h00002, "R6");
      evt(3'd2, 3'd0, 2'd0, "R6");
      evt(3'd4, 3'd1, 2'd0, "R6");
      evt(3'd5, 3'd3, 2'd0, "R6");
      evt(3'd3, 3'd2, 2'd0, "R6");
      evt(3'd1, 3'd0, 2'd0, "R6");
      // R7 vector routes
      for (int v = 0; v < 4; v++) evt(3'd2, 3'd6, 2'(v), "R7");
      evt(3'd4, 3'd6, 2'd1, "R7");
      // R8 corrected
      cfg(19'h00001, "R8");
      evt(3'd7, 3'd5, 2'd0, "R8");
      evt(3'd6, 3'd0, 2'd0, "R8");
      evt(3'd0, 3'd4, 2'd0, "R8");
      evt(3'd2, 3'd0, 2'd0, "R8");
      // R9 logged with all enables off
      cfg(19'h00000, "R9");
      step(1'b0, '0, 1'b0, 3'd0, 3'd0, 2'd0, '1, "R9");
      evt(3'd4, 3'd1, 2'd0, "R9");
      evt(3'd1, 3'd6, 2'd3, "R9");
      evt(3'd0, 3'd1, 2'd0, "R9");
      // R10 clear, and set beats clear
      step(1'b0, '0, 1'b0, 3'd0, 3'd0, 2'd0, 12'h200, "R10");
      step(1'b0, '0, 1'b1, 3'd1, 3'd6, 2'd0, '1, "R10");
      check(stat == 12'h040, "R10", "set wins", 32'(stat), 32'h040);
      // R11 back-to-back pulses
      cfg(19'h0000B, "R11");
      evt(3'd1, 3'd0, 2'd0, "R11");
      evt(3'd1, 3'd0, 2'd0, "R11");
      step(1'b0, '0, 1'b0, 3'd0, 3'd0, 2'd0, '0, "R11");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit            wr = ($urandom % 16) == 0;
         logic [RW-1:0] wd = RW'($urandom);
         bit            ev = ($urandom % 4) != 0;
         logic [NS-1:0] cl = (($urandom % 8) == 0) ? NS'($urandom) : '0;
         step(wr, wd, ev, 3'($urandom), 3'($urandom), 2'($urandom), cl,
              "R4 R5 R6 R7 R8 R9 R10 R11");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule